// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of an instruction decoder. It takes an instruction byte stream one byte per cycle over a valid/ready handshake. A mode input selects 64-bit operation or legacy operation. The scanner consumes the prefix bytes in front of an instruction and records each kind as a flag. It keeps the last segment override and the REX nibble that sits directly before the opcode. It captures the two-byte or three-byte VEX payload, then takes the primary opcode byte. For every instruction it presents one record for one cycle. The record holds the prefix flags, the segment code, the REX bits, the VEX kind and payload, the opcode, a pause indication, a branch-hint indication and a fault flag.

The scanner is lenient on purpose. Repeated prefixes, conflicting segment overrides, legacy prefixes after REX and repeat prefixes on opcodes that cannot repeat are all accepted without a fault. Only a misused LOCK, or an instruction that runs past the length limit, raises the fault flag. ModRM, SIB, displacement, immediates and escape opcode maps are left to later stages.

A single state machine controls the scan. Its states are:
- `SC_PREFIX`: collects prefixes or takes the opcode.
- `SC_VEXP1`: takes the first VEX payload byte.
- `SC_VEXP2`: takes the second VEX payload byte, for the three-byte form only.
- `SC_VEXOP`: takes the opcode that follows a VEX payload.
- `SC_EMIT`: presents the record.

Its transitions are:
- prefix → prefix, on a prefix byte.
- prefix → vexp1, on 0xC5 or 0xC4.
- vexp1 → vexp2, for the three-byte form.
- vexp1 → vexop, for the two-byte form.
- vexp2 → vexop.
- prefix or vexop → emit, on the opcode.
- Any scan state → emit, on the 16th byte.
- emit → prefix, unconditionally after one cycle.

Top module: `instr_prefix_scanner`

## Requirements
- R1: Byte 0xF0 sets `rec_lock`, 0xF2 sets `rec_repne`, 0xF3 sets `rec_rep`, 0x66 sets `rec_opsize` and 0x67 sets `rec_adsize`. Any of these may repeat any number of times without a fault.
- R2: The segment override bytes map to `rec_seg` codes as follows: 0x26→0, 0x2E→1, 0x36→2, 0x3E→3, 0x64→4, 0x65→5. Any override sets `rec_seg_valid`. With several overrides the last one sets the code, and no fault is raised.
- R3: When `mode64`=1, bytes 0x40–0x4F are REX prefixes: they set `rec_rex_valid` and put the byte's low nibble in `rec_rex`. When `mode64`=0 the same bytes are opcodes and end the instruction.
- R4: A REX prefix takes effect only if it comes directly before the opcode. A later legacy prefix or VEX escape clears it, and a legacy prefix after REX raises no fault. Of two REX bytes in a row, the later one counts.
- R5: 0xC5 starts a two-byte VEX (`rec_vex_kind`=1, payload in `rec_vex_payload[7:0]`, upper byte zero). 0xC4 starts a three-byte VEX (`rec_vex_kind`=2, first payload byte in bits [15:8], second in [7:0]). The byte after the payload is always taken as the opcode, whatever its value. `rec_vex_kind` is 0 when no VEX is present.
- R6: `rec_pause` is 1 when an 0xF3 prefix was seen, the opcode is 0x90 and no VEX is present. An 0xF3 on any other opcode raises no fault.
- R7: `rec_hint` is 1 when a segment override was seen, the opcode is in 0x70–0x7F and no VEX is present. The segment code is still reported.
- R8: `rec_fault` is 1 when LOCK was seen and either a VEX is present or the opcode is not lockable. The lockable opcodes are 0x00/01/08/09/10/11/18/19/20/21/28/29/30/31, 0x80–0x83, 0x86, 0x87, 0xF6, 0xF7, 0xFE, 0xFF and 0x0F.
- R9: If 15 bytes of an instruction have been consumed without an opcode, the 16th byte ends the record. That record has `rec_fault`=1, `rec_opcode` equal to the 16th byte, and `rec_pause` and `rec_hint` both 0. The next byte starts a new instruction.
- R10: After reset `rec_valid`=0 and `in_ready`=1. The record is valid for exactly the one cycle after the edge that accepts the final byte. During that cycle `in_ready` is 0; in every other cycle it is 1.
- R11: Each record reflects only the bytes of its own instruction. All flags and fields are cleared between instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 selects 64-bit byte interpretation |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Scanner can take a byte this cycle |
| rec_valid | output | 1 | Record fields are valid |
| rec_lock | output | 1 | LOCK seen |
| rec_repne | output | 1 | 0xF2 repeat seen |
| rec_rep | output | 1 | 0xF3 repeat seen |
| rec_opsize | output | 1 | Operand-size override seen |
| rec_adsize | output | 1 | Address-size override seen |
| rec_seg_valid | output | 1 | A segment override was seen |
| rec_seg | output | 3 | Code of the last segment override |
| rec_rex_valid | output | 1 | REX in effect |
| rec_rex | output | 4 | REX low nibble |
| rec_vex_kind | output | 2 | 0 none, 1 two-byte, 2 three-byte |
| rec_vex_payload | output | 16 | VEX payload bytes |
| rec_opcode | output | 8 | Primary opcode, or the 16th byte on overrun |
| rec_pause | output | 1 | Spin-wait pause form |
| rec_hint | output | 1 | Branch hint form |
| rec_fault | output | 1 | LOCK misuse or length overrun |

## Verification
On every cycle, the assertions check the following:
- A record lasts one cycle, and capturing an opcode after a VEX payload leads straight to a record.
- Pause and hint are never reported without their required prefix and opcode context.
- REX and VEX never coexist in a record.
- A fault without LOCK only ever follows a length overrun.

Only the bench's scenarios can show the rest:
- The real value of each field.
- The mode-dependent reading of 0x40–0x4F.
- Last-wins segment selection.
- REX discard.
- The exact lockable set.
- Resynchronisation after an overlong instruction.

These are checked against a model of the rules, over directed cases and seeded random streams with idle gaps.

// File: rtl/pfx_scan_pkg.sv
`timescale 1ns/1ps
package pfx_scan_pkg;

    typedef enum logic [3:0] {
        BK_OPCODE,
        BK_LOCK,
        BK_REPNE,
        BK_REPE,
        BK_SEG,
        BK_OPSZ,
        BK_ADSZ,
        BK_REX,
        BK_VEX2,
        BK_VEX3
    } byte_kind_e;

    typedef enum logic [2:0] {
        SC_PREFIX,
        SC_VEXP1,
        SC_VEXP2,
        SC_VEXOP,
        SC_EMIT
    } scan_state_e;

    typedef enum logic [1:0] {
        VX_NONE  = 2'd0,
        VX_SHORT = 2'd1,
        VX_LONG  = 2'd2
    } vex_kind_e;

endpackage

// File: rtl/pfx_byte_class.sv
`timescale 1ns/1ps
module pfx_byte_class
    import pfx_scan_pkg::*;
(
    input  logic [7:0]  byte_i,
    input  logic        mode64_i,
    output byte_kind_e  kind_o,
    output logic [2:0]  seg_o
);

    always_comb begin
        kind_o = BK_OPCODE;
        seg_o  = 3'd0;
        case (byte_i)
            8'hF0: kind_o = BK_LOCK;
            8'hF2: kind_o = BK_REPNE;
            8'hF3: kind_o = BK_REPE;
            8'h66: kind_o = BK_OPSZ;
            8'h67: kind_o = BK_ADSZ;
            8'h26: begin kind_o = BK_SEG; seg_o = 3'd0; end
            8'h2E: begin kind_o = BK_SEG; seg_o = 3'd1; end
            8'h36: begin kind_o = BK_SEG; seg_o = 3'd2; end
            8'h3E: begin kind_o = BK_SEG; seg_o = 3'd3; end
            8'h64: begin kind_o = BK_SEG; seg_o = 3'd4; end
            8'h65: begin kind_o = BK_SEG; seg_o = 3'd5; end
            8'hC5: kind_o = BK_VEX2;
            8'hC4: kind_o = BK_VEX3;
            default: begin
                // R3: the 0x4x row is REX only in 64-bit mode
                if (mode64_i && (byte_i[7:4] == 4'h4)) begin
                    kind_o = BK_REX;
                end
            end
        endcase
    end

endmodule

// File: rtl/pfx_opcode_eval.sv
`timescale 1ns/1ps
module pfx_opcode_eval (
    input  logic [7:0] opc_i,
    input  logic       lock_i,
    input  logic       rep_i,
    input  logic       seg_i,
    input  logic       vex_i,
    output logic       lock_fault_o,
    output logic       pause_o,
    output logic       hint_o
);

    logic lockable;

    always_comb begin
        lockable = 1'b0;
        // ALU group with memory destination, compare excluded
        if ((opc_i[7:6] == 2'b00) && (opc_i[5:3] != 3'd7) && (opc_i[2:1] == 2'b00)) begin
            lockable = 1'b1;
        end
        case (opc_i)
            8'h80, 8'h81, 8'h82, 8'h83,
            8'h86, 8'h87,
            8'hF6, 8'hF7, 8'hFE, 8'hFF,
            8'h0F: lockable = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        lock_fault_o = lock_i && (vex_i || !lockable);               // R8
        pause_o      = rep_i && !vex_i && (opc_i == 8'h90);          // R6
        hint_o       = seg_i && !vex_i && (opc_i[7:4] == 4'h7);      // R7
    end

endmodule

// File: rtl/instr_prefix_scanner.sv
`timescale 1ns/1ps
module instr_prefix_scanner
    import pfx_scan_pkg::*;
#(
    parameter int MAX_LEN = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode64,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    output logic        rec_valid,
    output logic        rec_lock,
    output logic        rec_repne,
    output logic        rec_rep,
    output logic        rec_opsize,
    output logic        rec_adsize,
    output logic        rec_seg_valid,
    output logic [2:0]  rec_seg,
    output logic        rec_rex_valid,
    output logic [3:0]  rec_rex,
    output logic [1:0]  rec_vex_kind,
    output logic [15:0] rec_vex_payload,
    output logic [7:0]  rec_opcode,
    output logic        rec_pause,
    output logic        rec_hint,
    output logic        rec_fault
);

    localparam int CNT_W = $clog2(MAX_LEN + 2);
    localparam logic [CNT_W-1:0] LEN_LIMIT = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] LEN_OVER  = CNT_W'(MAX_LEN + 1);

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    logic        lock_q, repne_q, rep_q, osz_q, asz_q;
    logic        segv_q;
    logic [2:0]  seg_q;
    logic        rexv_q;
    logic [3:0]  rex_q;
    vex_kind_e   vk_q;
    logic [15:0] vpl_q;
    logic [7:0]  opc_q;
    logic        pause_q, hint_q, fault_q;

    byte_kind_e  kind_w;
    logic [2:0]  seg_w;
    logic        lockf_w, pause_w, hint_w;
    logic        accept, overlong, opc_capture;

    pfx_byte_class u_class (
        .byte_i   (in_byte),
        .mode64_i (mode64),
        .kind_o   (kind_w),
        .seg_o    (seg_w)
    );

    pfx_opcode_eval u_eval (
        .opc_i        (in_byte),
        .lock_i       (lock_q),
        .rep_i        (rep_q),
        .seg_i        (segv_q),
        .vex_i        (vk_q != VX_NONE),
        .lock_fault_o (lockf_w),
        .pause_o      (pause_w),
        .hint_o       (hint_w)
    );

    assign accept      = in_valid && in_ready;
    assign overlong    = accept && (cnt_q == LEN_LIMIT);
    assign opc_capture = accept && !overlong &&
                         (((state_q == SC_PREFIX) && (kind_w == BK_OPCODE)) ||
                          (state_q == SC_VEXOP));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_PREFIX;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_PREFIX: begin
                if (accept) begin
                    if (overlong) begin
                        state_d = SC_EMIT;
                    end else if (kind_w == BK_OPCODE) begin
                        state_d = SC_EMIT;
                    end else if ((kind_w == BK_VEX2) || (kind_w == BK_VEX3)) begin
                        state_d = SC_VEXP1;
                    end
                end
            end
            SC_VEXP1: begin
                if (accept) begin
                    if (overlong)            state_d = SC_EMIT;
                    else if (vk_q == VX_LONG) state_d = SC_VEXP2;
                    else                     state_d = SC_VEXOP;
                end
            end
            SC_VEXP2: begin
                if (accept) begin
                    state_d = overlong ? SC_EMIT : SC_VEXOP;
                end
            end
            SC_VEXOP: begin
                if (accept) state_d = SC_EMIT;
            end
            SC_EMIT:  state_d = SC_PREFIX;
            default:  state_d = SC_PREFIX;
        endcase
    end

    // record accumulation
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q == SC_EMIT)) begin
            cnt_q   <= '0;
            lock_q  <= 1'b0;
            repne_q <= 1'b0;
            rep_q   <= 1'b0;
            osz_q   <= 1'b0;
            asz_q   <= 1'b0;
            segv_q  <= 1'b0;
            seg_q   <= 3'd0;
            rexv_q  <= 1'b0;
            rex_q   <= 4'd0;
            vk_q    <= VX_NONE;
            vpl_q   <= 16'd0;
            opc_q   <= 8'd0;
            pause_q <= 1'b0;
            hint_q  <= 1'b0;
            fault_q <= 1'b0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            if (overlong) begin
                opc_q   <= in_byte;     // R9
                fault_q <= 1'b1;
                pause_q <= 1'b0;
                hint_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    SC_PREFIX: begin
                        case (kind_w)
                            BK_LOCK:  begin lock_q  <= 1'b1; rexv_q <= 1'b0; rex_q <= 4'd0; end
                            BK_REPNE: begin repne_q <= 1'b1; rexv_q <= 1'b0; rex_q <= 4'd0; end
                            BK_REPE:  begin rep_q   <= 1'b1; rexv_q <= 1'b0; rex_q <= 4'd0; end
                            BK_OPSZ:  begin osz_q   <= 1'b1; rexv_q <= 1'b0; rex_q <= 4'd0; end
                            BK_ADSZ:  begin asz_q   <= 1'b1; rexv_q <= 1'b0; rex_q <= 4'd0; end
                            BK_SEG: begin
                                segv_q <= 1'b1;
                                seg_q  <= seg_w;    // R2 last wins
                                rexv_q <= 1'b0;
                                rex_q  <= 4'd0;
                            end
                            BK_REX: begin
                                rexv_q <= 1'b1;
                                rex_q  <= in_byte[3:0];
                            end
                            BK_VEX2: begin
                                vk_q   <= VX_SHORT;
                                rexv_q <= 1'b0;
                                rex_q  <= 4'd0;
                            end
                            BK_VEX3: begin
                                vk_q   <= VX_LONG;
                                rexv_q <= 1'b0;
                                rex_q  <= 4'd0;
                            end
                            default: ;
                        endcase
                    end
                    SC_VEXP1: begin
                        if (vk_q == VX_LONG) vpl_q[15:8] <= in_byte;
                        else                 vpl_q[7:0]  <= in_byte;
                    end
                    SC_VEXP2: vpl_q[7:0] <= in_byte;
                    default: ;
                endcase
                if (opc_capture) begin
                    opc_q   <= in_byte;
                    pause_q <= pause_w;
                    hint_q  <= hint_w;
                    fault_q <= lockf_w;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rec_valid       = (state_q == SC_EMIT);
        in_ready        = (state_q != SC_EMIT);
        rec_lock        = lock_q;
        rec_repne       = repne_q;
        rec_rep         = rep_q;
        rec_opsize      = osz_q;
        rec_adsize      = asz_q;
        rec_seg_valid   = segv_q;
        rec_seg         = seg_q;
        rec_rex_valid   = rexv_q;
        rec_rex         = rex_q;
        rec_vex_kind    = vk_q;
        rec_vex_payload = vpl_q;
        rec_opcode      = opc_q;
        rec_pause       = pause_q;
        rec_hint        = hint_q;
        rec_fault       = fault_q;
    end

    assert_emit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    assert_vexop_emits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (state_q == SC_VEXOP)) |=> rec_valid);

    assert_pause_context_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_pause) |-> (rec_rep && (rec_opcode == 8'h90) && (rec_vex_kind == 2'd0)));

    assert_hint_context_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_hint) |-> (rec_seg_valid && (rec_opcode[7:4] == 4'h7)));

    assert_rex_vex_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_rex_valid) |-> (rec_vex_kind == 2'd0));

    assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_fault && !rec_lock) |-> (cnt_q == LEN_OVER));

    assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LEN_OVER);

endmodule

// File: tb/instr_prefix_scanner_bench.sv
`timescale 1ns/1ps
module instr_prefix_scanner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'd0;
    logic        in_ready, rec_valid;
    logic        rec_lock, rec_repne, rec_rep, rec_opsize, rec_adsize;
    logic        rec_seg_valid, rec_rex_valid;
    logic [2:0]  rec_seg;
    logic [3:0]  rec_rex;
    logic [1:0]  rec_vex_kind;
    logic [15:0] rec_vex_payload;
    logic [7:0]  rec_opcode;
    logic        rec_pause, rec_hint, rec_fault;

    int total = 0;
    int bad   = 0;

    logic [7:0] seq [0:19];
    int         seq_n;
    logic       seq_m64;

    always #10 clk = ~clk;

    instr_prefix_scanner u_instr_prefix_scanner (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .rec_valid(rec_valid), .rec_lock(rec_lock), .rec_repne(rec_repne),
        .rec_rep(rec_rep), .rec_opsize(rec_opsize), .rec_adsize(rec_adsize),
        .rec_seg_valid(rec_seg_valid), .rec_seg(rec_seg),
        .rec_rex_valid(rec_rex_valid), .rec_rex(rec_rex),
        .rec_vex_kind(rec_vex_kind), .rec_vex_payload(rec_vex_payload),
        .rec_opcode(rec_opcode), .rec_pause(rec_pause), .rec_hint(rec_hint),
        .rec_fault(rec_fault)
    );

    logic [42:0] act;
    assign act = {rec_lock, rec_repne, rec_rep, rec_opsize, rec_adsize,
                  rec_seg_valid, rec_seg, rec_rex_valid, rec_rex,
                  rec_vex_kind, rec_vex_payload, rec_opcode,
                  rec_pause, rec_hint, rec_fault};

    function automatic bit can_lock(input logic [7:0] b);
        return b inside {8'h00, 8'h01, 8'h08, 8'h09, 8'h10, 8'h11, 8'h18, 8'h19,
                         8'h20, 8'h21, 8'h28, 8'h29, 8'h30, 8'h31,
                         8'h80, 8'h81, 8'h82, 8'h83, 8'h86, 8'h87,
                         8'hF6, 8'hF7, 8'hFE, 8'hFF, 8'h0F};
    endfunction

    function automatic bit is_pfx(input logic [7:0] b, input logic m64);
        if (b inside {8'hF0, 8'hF2, 8'hF3, 8'h66, 8'h67, 8'h26, 8'h2E,
                      8'h36, 8'h3E, 8'h64, 8'h65, 8'hC4, 8'hC5}) return 1'b1;
        return m64 && (b[7:4] == 4'h4);
    endfunction

    // expected record from the rules
    function automatic logic [42:0] model();
        logic lk = 0, f2 = 0, f3 = 0, os = 0, as_ = 0, sv = 0, rv = 0;
        logic pa = 0, hi = 0, fa = 0, ovl = 0;
        logic [2:0] sg = 0;
        logic [3:0] rx = 0;
        logic [1:0] vk = 0;
        logic [15:0] vp = 0;
        logic [7:0] op = 0;
        int ph = 0;
        for (int i = 0; i < seq_n; i++) begin
            logic [7:0] b;
            b = seq[i];
            if (i == 15) begin op = b; ovl = 1; break; end
            if (ph == 1) begin
                if (vk == 2) begin vp[15:8] = b; ph = 2; end
                else begin vp[7:0] = b; ph = 3; end
            end else if (ph == 2) begin
                vp[7:0] = b; ph = 3;
            end else if (ph == 3) begin
                op = b; break;
            end else if (b == 8'hF0) begin lk = 1; rv = 0; rx = 0;
            end else if (b == 8'hF2) begin f2 = 1; rv = 0; rx = 0;
            end else if (b == 8'hF3) begin f3 = 1; rv = 0; rx = 0;
            end else if (b == 8'h66) begin os = 1; rv = 0; rx = 0;
            end else if (b == 8'h67) begin as_ = 1; rv = 0; rx = 0;
            end else if (b inside {8'h26, 8'h2E, 8'h36, 8'h3E}) begin
                sv = 1; sg = {1'b0, b[4:3]}; rv = 0; rx = 0;
            end else if (b == 8'h64 || b == 8'h65) begin
                sv = 1; sg = {2'b10, b[0]}; rv = 0; rx = 0;
            end else if (b == 8'hC5) begin vk = 1; ph = 1; rv = 0; rx = 0;
            end else if (b == 8'hC4) begin vk = 2; ph = 1; rv = 0; rx = 0;
            end else if (seq_m64 && b[7:4] == 4'h4) begin rv = 1; rx = b[3:0];
            end else begin op = b; break; end
        end
        if (ovl) begin
            fa = 1;
        end else begin
            pa = f3 && (op == 8'h90) && (vk == 0);
            hi = sv && (op[7:4] == 4'h7) && (vk == 0);
            fa = lk && ((vk != 0) || !can_lock(op));
        end
        return {lk, f2, f3, os, as_, sv, sg, rv, rx, vk, vp, op, pa, hi, fa};
    endfunction

    task automatic run_check(input string tag);
        logic [42:0] exp;
        exp = model();
        for (int i = 0; i < seq_n; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 4) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = seq[i];
            mode64   = seq_m64;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'd0;
        total++;
        if (!rec_valid || act !== exp) begin
            bad++;
            $display("FAIL %s: valid=%0b rec=%h exp=%h", tag, rec_valid, act, exp);
        end
        total++;
        if (in_ready !== 1'b0) begin
            bad++;
            $display("FAIL R10 ready during record: got %0b exp 0", in_ready);
        end
        @(negedge clk);
        total++;
        if (rec_valid !== 1'b0 || in_ready !== 1'b1) begin
            bad++;
            $display("FAIL R10 after record: valid=%0b ready=%0b exp 0/1", rec_valid, in_ready);
        end
    endtask

    task automatic set2(input logic m, input logic [7:0] a, input logic [7:0] b);
        seq_m64 = m; seq_n = 2; seq[0] = a; seq[1] = b;
    endtask

    task automatic set4(input logic m, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] d, input int n);
        seq_m64 = m; seq_n = n; seq[0] = a; seq[1] = b; seq[2] = c; seq[3] = d;
    endtask

    function automatic logic [7:0] legacy_pick(input int r);
        case (r)
            0: return 8'hF0;  1: return 8'hF2;  2: return 8'hF3;  3: return 8'h66;
            4: return 8'h67;  5: return 8'h26;  6: return 8'h2E;  7: return 8'h36;
            8: return 8'h3E;  9: return 8'h64;  default: return 8'h65;
        endcase
    endfunction

    task automatic gen_random();
        int np;
        logic [7:0] b;
        seq_m64 = 1'($urandom_range(0, 1));
        seq_n = 0;
        np = $urandom_range(0, 6);
        for (int k = 0; k < np; k++) begin
            if ($urandom_range(0, 4) == 0 && seq_m64)
                seq[seq_n] = {4'h4, 4'($urandom_range(0, 15))};
            else
                seq[seq_n] = legacy_pick($urandom_range(0, 10));
            seq_n++;
        end
        if ($urandom_range(0, 3) == 0) begin
            if ($urandom_range(0, 1) == 0) begin
                seq[seq_n] = 8'hC5; seq[seq_n+1] = 8'($urandom); seq_n += 2;
            end else begin
                seq[seq_n] = 8'hC4; seq[seq_n+1] = 8'($urandom);
                seq[seq_n+2] = 8'($urandom); seq_n += 3;
            end
            seq[seq_n] = 8'($urandom);
        end else begin
            do begin
                case ($urandom_range(0, 3))
                    0: b = 8'h90;
                    1: b = {4'h7, 4'($urandom_range(0, 15))};
                    2: b = can_lock(8'($urandom)) ? 8'h01 : 8'hFF;
                    default: b = 8'($urandom);
                endcase
            end while (is_pfx(b, seq_m64));
            seq[seq_n] = b;
        end
        seq_n++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        total++;
        if (rec_valid !== 1'b0 || in_ready !== 1'b1) begin
            bad++;
            $display("FAIL R10 reset: valid=%0b ready=%0b exp 0/1", rec_valid, in_ready);
        end
        rst_n = 1'b1;

        set4(0, 8'h66, 8'h67, 8'hF2, 8'hA4, 4);  run_check("R1 flag prefixes");
        set4(0, 8'h66, 8'h66, 8'h66, 8'h8B, 4);  run_check("R1 repeated opsize");
        set4(0, 8'h26, 8'h65, 8'h8B, 8'h00, 3);  run_check("R2 two segments last wins");
        set4(1, 8'h3E, 8'h2E, 8'h36, 8'h8B, 4);  run_check("R2 three segments");
        set2(1, 8'h48, 8'h89);                   run_check("R3 rex in 64-bit mode");
        seq_m64 = 0; seq_n = 1; seq[0] = 8'h48;  run_check("R3 legacy 0x48 is opcode");
        set4(1, 8'h48, 8'h66, 8'h01, 8'h00, 3);  run_check("R4 legacy after rex");
        set4(1, 8'h41, 8'h4C, 8'h89, 8'h00, 3);  run_check("R4 later rex counts");
        set4(1, 8'h41, 8'hC5, 8'hF8, 8'h77, 4);  run_check("R4 rex before vex dropped");
        set4(1, 8'hC4, 8'hE2, 8'h79, 8'h66, 4);  run_check("R5 three-byte vex");
        set4(0, 8'hC5, 8'hF0, 8'hF0, 8'h00, 3);  run_check("R5 prefix-like opcode after vex");
        set2(0, 8'hF3, 8'h90);                   run_check("R6 pause");
        set4(0, 8'hF3, 8'hF3, 8'h8B, 8'h00, 3);  run_check("R6 rep on plain opcode");
        set4(1, 8'hF3, 8'hC5, 8'hF8, 8'h90, 4);  run_check("R6 no pause with vex");
        set2(0, 8'h2E, 8'h74);                   run_check("R7 branch hint");
        set2(1, 8'h3E, 8'h7F);                   run_check("R7 branch hint 0x7F");
        set2(0, 8'hF0, 8'h90);                   run_check("R8 lock on non-lockable");
        set4(0, 8'hF0, 8'hF0, 8'h01, 8'h00, 3);  run_check("R8 lock on lockable");
        set2(0, 8'hF0, 8'h38);                   run_check("R8 lock on compare");
        set4(0, 8'hF0, 8'hC5, 8'hF8, 8'h10, 4);  run_check("R8 lock with vex");
        seq_m64 = 0; seq_n = 16;
        for (int i = 0; i < 16; i++) seq[i] = 8'h2E;
        run_check("R9 overlong");
        seq_m64 = 1; seq_n = 16;
        for (int i = 0; i < 14; i++) seq[i] = 8'h66;
        seq[14] = 8'hC5; seq[15] = 8'hF8;
        run_check("R9 overlong inside vex");
        seq_m64 = 0; seq_n = 1; seq[0] = 8'h90;  run_check("R9 resync after overlong");
        set2(0, 8'h2E, 8'h8B);                   run_check("R11 clean record after seg");

        for (int t = 0; t < 400; t++) begin
            gen_random();
            run_check("R11 random stream");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule